// File: doc/BRIEF.md
# Command Stream Header Decoder

The decoder walks a command list held in a word-addressed memory. It starts when `start` is pulsed, at the word address `list_base`, and covers `list_len` words. It reads each header word and unpacks it. Depending on the submission mode in the header, it reads zero or more argument words after the header. It then emits a sequence of register writes, each made of a method, a subchannel and a 32-bit value, on a valid/ready output port. Downstream engines consume these writes. The decoder does not interpret methods.

One header can expand into a burst of writes of any length. In that burst the method either steps by one per argument, stays fixed, or steps once after the first argument. An inline mode instead carries a 13-bit value inside the header and produces one write without reading any data word. The decoder handles malformed content without hanging:
- An undefined mode is skipped and flagged.
- An increment-once header with no arguments is flagged.
- A burst that would run past the end of the list stops the decoder with an overrun flag.

`done` pulses once when the list has been consumed or decoding has stopped.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: A header word is split as follows: method in bits 12:0, subchannel in bits 15:13, argument count (or inline value) in bits 28:16, and mode in bits 31:29. Every write emitted for a header carries that header's subchannel.
- R2: Modes 0 and 1 (incrementing) take one data word per argument, in list order. Argument i goes to method+i, computed modulo 2^13.
- R3: Modes 2 and 3 (fixed) write every argument to the header's method.
- R4: Mode 5 (increment-once) writes the first argument to the method and every later argument to method+1.
- R5: Mode 5 with a count of zero emits no write and sets the sticky `err_zero_count` flag. Decoding continues with the next word.
- R6: Mode 4 (inline) emits exactly one write whose value is bits 28:16 of the header, zero-extended to 32 bits. It reads no data word, so the next word is a header.
- R7: Modes 6 and 7 emit nothing and set the sticky `err_bad_mode` flag. Decoding continues with the next word.
- R8: A count of zero in modes 0 to 3 emits no write, and the next word is treated as a header.
- R9: While `out_valid` is high and `out_ready` is low, the method, subchannel and value hold steady. No memory read is issued while `out_valid` is high.
- R10: If a header's argument count exceeds the words left in the list, `err_overrun` is set, no write is emitted for that header, and decoding stops. No address at or beyond `list_base+list_len` is ever read.
- R11: `done` is high for exactly one cycle per run, after the final write has been accepted or after an overrun stop. A zero-length list raises `done` with no memory read.
- R12: After reset, `out_valid`, `done`, `mem_rd_en` and all error flags are low. A new `start` clears the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding a list (accepted when idle) |
| list_base | input | AW | Word address of the first list word |
| list_len | input | LW | List length in words |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| out_valid | output | 1 | Register write available |
| out_ready | input | 1 | Downstream accepts the write |
| out_method | output | 13 | Method of the write |
| out_subch | output | 3 | Subchannel of the write |
| out_value | output | 32 | Value of the write |
| done | output | 1 | One-cycle pulse when the run ends |
| err_bad_mode | output | 1 | Sticky: an undefined mode was seen |
| err_zero_count | output | 1 | Sticky: an increment-once header had no arguments |
| err_overrun | output | 1 | Sticky: a burst ran past the list end |

## Verification
The hardest condition to reach is an argument burst whose count goes past the end of the list. In that case the decoder must stop without touching the words beyond the end. The stimulus builds a short list whose single header claims more arguments than the list holds. A monitor then flags any read address at or above the list end. The inline case is covered by a list that places a header directly after an inline header. If the inline write wrongly consumed a data word, every later write would decode differently. Backpressure is driven with an irregular ready pattern while the stall cycles are checked for stable output and no memory reads.

// File: rtl/cmdp_pkg.sv
`timescale 1ns/1ps
package cmdp_pkg;

    localparam int METH_W = 13;
    localparam int SUB_W  = 3;
    localparam int CNT_W  = 13;
    localparam int MODE_W = 3;
    localparam int WORD_W = 32;

    // Packed header: mode[31:29] count/imm[28:16] subchannel[15:13] method[12:0]
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  cnt;
        logic [SUB_W-1:0]  sub;
        logic [METH_W-1:0] meth;
    } hdr_t;

    typedef enum logic [2:0] {
        K_INC,
        K_FIXED,
        K_ONCE,
        K_IMM,
        K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR_RD,
        S_HDR_DEC,
        S_ARG_RD,
        S_ARG_CAP,
        S_EMIT
    } st_e;

    typedef struct packed {
        logic [METH_W-1:0] meth;
        logic [SUB_W-1:0]  sub;
        logic [WORD_W-1:0] val;
    } wr_t;

    function automatic kind_e kind_of(input logic [MODE_W-1:0] m);
        kind_e k;
        case (m)
            3'd0, 3'd1: k = K_INC;
            3'd2, 3'd3: k = K_FIXED;
            3'd4:       k = K_IMM;
            3'd5:       k = K_ONCE;
            default:    k = K_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cmdp_list_track.sv
`timescale 1ns/1ps
module cmdp_list_track
    import cmdp_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [AW-1:0]    base,
    input  logic [LW-1:0]    len,
    input  logic [CNT_W-1:0] need,
    output logic [AW-1:0]    ptr,
    output logic             at_end,
    output logic             fits
);
    localparam int MX = (AW > LW) ? AW : LW;
    localparam int PW = ((MX > CNT_W) ? MX : CNT_W) + 2;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            end_q <= '0;
        end else if (load) begin
            ptr_q <= PW'(base);
            end_q <= PW'(base) + PW'(len);
        end else if (step) begin
            ptr_q <= ptr_q + PW'(1);
        end
    end

    assign ptr    = ptr_q[AW-1:0];
    assign at_end = (ptr_q >= end_q);
    assign fits   = ((ptr_q + PW'(need)) <= end_q);

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= end_q); // R10

    AST_STEP_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |-> (ptr_q < end_q)); // R10

endmodule

// File: rtl/cmdp_meth_gen.sv
`timescale 1ns/1ps
module cmdp_meth_gen
    import cmdp_pkg::*;
(
    input  kind_e             kind,
    input  logic [METH_W-1:0] base_meth,
    input  logic [CNT_W-1:0]  idx,
    output logic [METH_W-1:0] meth
);
    localparam logic [METH_W-1:0] ONE = METH_W'(1);

    always_comb begin
        case (kind)
            K_INC:   meth = base_meth + METH_W'(idx);
            K_ONCE:  meth = (idx == '0) ? base_meth : base_meth + ONE;
            default: meth = base_meth;
        endcase
    end

endmodule

// File: rtl/cmd_hdr_decoder.sv
`timescale 1ns/1ps
module cmd_hdr_decoder
    import cmdp_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     list_base,
    input  logic [LW-1:0]     list_len,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [METH_W-1:0] out_method,
    output logic [SUB_W-1:0]  out_subch,
    output logic [WORD_W-1:0] out_value,
    output logic              done,
    output logic              err_bad_mode,
    output logic              err_zero_count,
    output logic              err_overrun
);
    st_e              st;
    hdr_t             hdr_q;
    kind_e            kind_q;
    logic [CNT_W-1:0] idx_q;
    wr_t              out_q;

    hdr_t              h_in;
    kind_e             k_in;
    logic              at_end;
    logic              fits;
    logic              load;
    logic              last_arg;
    logic [METH_W-1:0] gen_meth;

    assign h_in     = hdr_t'(mem_rd_data);
    assign k_in     = kind_of(h_in.mode);
    assign load     = (st == S_IDLE) && start;
    assign last_arg = (idx_q == (hdr_q.cnt - CNT_W'(1)));
    assign mem_rd_en = ((st == S_HDR_RD) && !at_end) || (st == S_ARG_RD);

    cmdp_list_track #(.AW(AW), .LW(LW)) u_track (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (mem_rd_en),
        .base   (list_base),
        .len    (list_len),
        .need   (h_in.cnt),
        .ptr    (mem_rd_addr),
        .at_end (at_end),
        .fits   (fits)
    );

    cmdp_meth_gen u_meth (
        .kind      (kind_q),
        .base_meth (hdr_q.meth),
        .idx       (idx_q),
        .meth      (gen_meth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= S_IDLE;
            hdr_q          <= '0;
            kind_q         <= K_INC;
            idx_q          <= '0;
            out_q          <= '0;
            out_valid      <= 1'b0;
            done           <= 1'b0;
            err_bad_mode   <= 1'b0;
            err_zero_count <= 1'b0;
            err_overrun    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        err_bad_mode   <= 1'b0;
                        err_zero_count <= 1'b0;
                        err_overrun    <= 1'b0;
                        st             <= S_HDR_RD;
                    end
                end
                S_HDR_RD: begin
                    if (at_end) begin
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else begin
                        st <= S_HDR_DEC;
                    end
                end
                S_HDR_DEC: begin
                    hdr_q  <= h_in;
                    kind_q <= k_in;
                    idx_q  <= '0;
                    if (k_in == K_BAD) begin
                        err_bad_mode <= 1'b1;
                        st           <= S_HDR_RD;
                    end else if (k_in == K_IMM) begin
                        out_q     <= '{meth: h_in.meth, sub: h_in.sub, val: WORD_W'(h_in.cnt)};
                        out_valid <= 1'b1;
                        st        <= S_EMIT;
                    end else if (h_in.cnt == '0) begin
                        if (k_in == K_ONCE) err_zero_count <= 1'b1;
                        st <= S_HDR_RD;
                    end else if (!fits) begin
                        err_overrun <= 1'b1;
                        done        <= 1'b1;
                        st          <= S_IDLE;
                    end else begin
                        st <= S_ARG_RD;
                    end
                end
                S_ARG_RD: st <= S_ARG_CAP;
                S_ARG_CAP: begin
                    out_q     <= '{meth: gen_meth, sub: hdr_q.sub, val: mem_rd_data};
                    out_valid <= 1'b1;
                    st        <= S_EMIT;
                end
                S_EMIT: begin
                    if (out_ready) begin
                        out_valid <= 1'b0;
                        if ((kind_q == K_IMM) || last_arg) begin
                            st <= S_HDR_RD;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                            st    <= S_ARG_RD;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign out_method = out_q.meth;
    assign out_subch  = out_q.sub;
    assign out_value  = out_q.val;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_method)
                                       && $stable(out_subch) && $stable(out_value))); // R9

    AST_NO_READ_WHILE_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mem_rd_en); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_BADMODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_bad_mode && !start) |=> err_bad_mode); // R7

    AST_IMM_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (kind_q == K_IMM)) |-> (out_value[WORD_W-1:CNT_W] == '0)); // R6

    AST_OVERRUN_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> (done && !out_valid)); // R10

endmodule

// File: tb/cmd_hdr_decoder_bench.sv
`timescale 1ns/1ps
module cmd_hdr_decoder_bench;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int NT = 11;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic [LW-1:0] list_len = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [12:0]   out_method;
    logic [2:0]    out_subch;
    logic [31:0]   out_value;
    logic          done;
    logic          err_bad_mode, err_zero_count, err_overrun;

    cmd_hdr_decoder #(.AW(AW), .LW(LW)) u_cmd_hdr_decoder (
        .clk(clk), .rst(rst), .start(start), .list_base(list_base), .list_len(list_len),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_method(out_method),
        .out_subch(out_subch), .out_value(out_value), .done(done),
        .err_bad_mode(err_bad_mode), .err_zero_count(err_zero_count), .err_overrun(err_overrun)
    );

    // Memory model: one-cycle read latency
    logic [31:0] mem [64];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[5:0]];

    // Ready pattern
    int rdy_mode = 0;
    int tgl = 0;
    always @(negedge clk) begin
        tgl = tgl + 1;
        out_ready = (rdy_mode != 0) ? ((tgl % 3) == 0) : 1'b1;
    end

    // Monitor
    int          cur_end = 0;
    int          n_cap = 0, n_reads = 0, n_done = 0, n_stall = 0;
    int          v_range = 0, v_rdval = 0, v_stable = 0;
    logic [12:0] cap_m [256];
    logic [2:0]  cap_s [256];
    logic [31:0] cap_v [256];
    bit          stall_prev = 0;
    logic [47:0] prev_t = '0;
    always begin
        @(negedge clk);
        #5;
        if (!rst) begin
            if (stall_prev && (!out_valid || prev_t != {out_method, out_subch, out_value}))
                v_stable = v_stable + 1;
            stall_prev = out_valid && !out_ready;
            if (stall_prev) n_stall = n_stall + 1;
            prev_t = {out_method, out_subch, out_value};
            if (out_valid && out_ready && n_cap < 256) begin
                cap_m[n_cap] = out_method;
                cap_s[n_cap] = out_subch;
                cap_v[n_cap] = out_value;
                n_cap = n_cap + 1;
            end
            if (mem_rd_en) begin
                n_reads = n_reads + 1;
                if (int'(mem_rd_addr) >= cur_end) v_range = v_range + 1;
                if (out_valid) v_rdval = v_rdval + 1;
            end
            if (done) n_done = n_done + 1;
        end
    end

    int nchecks = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks = nchecks + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int mode, input int cnt, input int sub, input int meth);
        logic [31:0] w;
        w = {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
        return w;
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R2";
            2, 3:    return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7, 8:    return "R7";
            9:       return "R8";
            default: return "R10";
        endcase
    endfunction

    // Stimulus/expected table: header, list length, writes, first method, last method,
    // error flags {bad,zero,over}, inline value
    localparam logic [31:0] T_HDR [NT] = '{
        mk(1, 3, 2, 'h010), mk(0, 2, 7, 'h1FFF), mk(3, 3, 1, 'h040), mk(2, 1, 0, 'h0AA),
        mk(5, 3, 3, 'h100), mk(5, 0, 3, 'h100), mk(4, 'h1ABC, 5, 'h055), mk(6, 2, 0, 'h007),
        mk(7, 0, 1, 'h009), mk(1, 0, 2, 'h030), mk(1, 5, 0, 'h050)};
    localparam int T_LEN [NT] = '{4, 3, 4, 2, 4, 1, 1, 1, 1, 1, 3};
    localparam int T_NW  [NT] = '{3, 2, 3, 1, 3, 0, 1, 0, 0, 0, 0};
    localparam int T_M0  [NT] = '{'h010, 'h1FFF, 'h040, 'h0AA, 'h100, 0, 'h055, 0, 0, 0, 0};
    localparam int T_ML  [NT] = '{'h012, 'h0000, 'h040, 'h0AA, 'h101, 0, 'h055, 0, 0, 0, 0};
    localparam logic [2:0] T_ERR [NT] = '{3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b010,
                                          3'b000, 3'b100, 3'b100, 3'b000, 3'b001};
    localparam int T_IV  [NT] = '{0, 0, 0, 0, 0, 0, 'h1ABC, 0, 0, 0, 0};

    task automatic run_list(input int base, input int len, output bit got);
        cur_end = base + len;
        @(negedge clk);
        list_base = AW'(base);
        list_len  = LW'(len);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        for (int c = 0; c < 1000 && !got; c++) begin
            @(negedge clk);
            #6;
            if (done) got = 1;
        end
        @(negedge clk);
    endtask

    task automatic run_entry(input int i, input string extra);
        int  c0, d0, r0, s0, q0, nw, bad_s, bad_v;
        bit  got;
        logic [31:0] ev;
        mem[8] = T_HDR[i];
        for (int k = 1; k < 16; k++) mem[8 + k] = 32'hD000_0000 | (i << 8) | k;
        c0 = n_cap; d0 = n_done; r0 = v_range; s0 = v_stable; q0 = v_rdval;
        run_list(8, T_LEN[i], got);
        chk(got, {tag_of(i), " R11 done seen", extra}, 32'(got), 1);
        nw = n_cap - c0;
        chk(nw == T_NW[i], {tag_of(i), " write count", extra}, nw, T_NW[i]);
        if (nw > 0 && nw == T_NW[i]) begin
            chk(cap_m[c0] == 13'(T_M0[i]), {tag_of(i), " first method", extra}, cap_m[c0], T_M0[i]);
            chk(cap_m[c0 + nw - 1] == 13'(T_ML[i]), {tag_of(i), " last method", extra},
                cap_m[c0 + nw - 1], T_ML[i]);
            bad_s = 0; bad_v = 0;
            for (int k = 0; k < nw; k++) begin
                ev = (T_HDR[i][31:29] == 3'd4) ? 32'(T_IV[i]) : mem[9 + k];
                if (cap_s[c0 + k] != T_HDR[i][15:13]) bad_s++;
                if (cap_v[c0 + k] != ev) bad_v++;
            end
            chk(bad_s == 0, {"R1 subchannel of ", tag_of(i), extra}, bad_s, 0);
            chk(bad_v == 0, {tag_of(i), " values", extra}, bad_v, 0);
        end
        chk({err_bad_mode, err_zero_count, err_overrun} == T_ERR[i],
            {tag_of(i), " R12 error flags", extra},
            {err_bad_mode, err_zero_count, err_overrun}, T_ERR[i]);
        chk(v_range == r0, {"R10 read past list end ", tag_of(i), extra}, v_range - r0, 0);
        chk(v_rdval == q0, {"R9 read while valid ", tag_of(i), extra}, v_rdval - q0, 0);
        chk(v_stable == s0, {"R9 output stable ", tag_of(i), extra}, v_stable - s0, 0);
        chk(n_done - d0 == 1, {"R11 done width ", tag_of(i), extra}, n_done - d0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchecks + 1, nfail + 1);
        $finish;
    end

    initial begin
        int  c0, r0, rd0, st0;
        bit  got;
        for (int a = 0; a < 64; a++) mem[a] = '0;
        repeat (4) @(negedge clk);
        #6;
        // R12 reset state
        chk(!out_valid && !done && !mem_rd_en, "R12 reset outputs",
            {29'b0, out_valid, done, mem_rd_en}, 0);
        chk({err_bad_mode, err_zero_count, err_overrun} == 3'b000, "R12 reset errors",
            {err_bad_mode, err_zero_count, err_overrun}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NT; i++) run_entry(i, "");

        // R9 backpressure with an irregular ready pattern
        rdy_mode = 1;
        st0 = n_stall;
        run_entry(0, " stalled");
        run_entry(4, " stalled");
        chk(n_stall > st0, "R9 stalls exercised", n_stall - st0, 1);
        rdy_mode = 0;

        // R6/R7 multi-header list: inline header followed directly by a header
        mem[20] = mk(4, 'h0123, 6, 'h300);
        mem[21] = mk(1, 2, 1, 'h010);
        mem[22] = 32'hCAFE_0001;
        mem[23] = 32'hCAFE_0002;
        mem[24] = mk(7, 3, 0, 'h000);
        mem[25] = mk(3, 1, 4, 'h020);
        mem[26] = 32'hCAFE_0003;
        c0 = n_cap;
        r0 = v_range;
        run_list(20, 7, got);
        chk(got, "R11 multi done", 32'(got), 1);
        chk(n_cap - c0 == 4, "R6 multi write count", n_cap - c0, 4);
        chk({cap_m[c0], cap_s[c0]} == {13'h300, 3'd6} && cap_v[c0] == 32'h123,
            "R6 inline write", cap_v[c0], 32'h123);
        chk(cap_m[c0 + 1] == 13'h010 && cap_v[c0 + 1] == 32'hCAFE_0001,
            "R6 next word decoded as header", cap_v[c0 + 1], 32'hCAFE_0001);
        chk(cap_m[c0 + 2] == 13'h011 && cap_v[c0 + 2] == 32'hCAFE_0002,
            "R2 second argument", {19'b0, cap_m[c0 + 2]}, 32'h011);
        chk(cap_m[c0 + 3] == 13'h020 && cap_s[c0 + 3] == 3'd4 && cap_v[c0 + 3] == 32'hCAFE_0003,
            "R7 decoding continues after bad mode", cap_v[c0 + 3], 32'hCAFE_0003);
        chk(err_bad_mode && !err_overrun && !err_zero_count, "R7 sticky bad mode flag",
            {err_bad_mode, err_zero_count, err_overrun}, 3'b100);
        chk(v_range == r0, "R10 multi read range", v_range - r0, 0);

        // R11 zero-length list
        rd0 = n_reads;
        c0 = n_cap;
        run_list(40, 0, got);
        chk(got, "R11 zero-length done", 32'(got), 1);
        chk(n_reads == rd0, "R11 zero-length no reads", n_reads - rd0, 0);
        chk(n_cap == c0, "R11 zero-length no writes", n_cap - c0, 0);
        chk({err_bad_mode, err_zero_count, err_overrun} == 3'b000, "R12 start clears errors",
            {err_bad_mode, err_zero_count, err_overrun}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

endmodule